// File: doc/BRIEF.md
# Termination Calibration Request Sequencer

This controller takes requests for calibration from software or surrounding logic and services them for a set of termination calibration units. There are up to twelve units, one request bit per unit. A request vector is accepted only after it has held the same nonzero value at two consecutive rising clock edges while the sequencer is idle. The accepted vector becomes the pending set. Every selected unit then calibrates for a fixed, parameterised number of cycles.

After calibration the sequencer walks the pending set from unit 0 upward, one unit at a time. For each pending unit it opens a serial transfer window of fixed length by raising that unit's bit on a one-hot select output. It then retires the unit from the pending set. When nothing is left pending, it raises a one-cycle load strobe and returns to idle. The calibration engines and the serial-to-parallel datapath are outside the block: the select output gates the transfer, and the strobe commits the codes.

Top module: `term_cal_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all outputs are zero from the following cycle on, and any run in progress is abandoned.
- R2: When idle with nothing pending, a nonzero `cal_req` value that is identical at two consecutive rising edges is accepted at the second edge. From the next cycle, `cal_busy` and `shift_busy` both equal that value.
- R3: A request present at only one edge, or one that changes value between the two edges, is not accepted. `shift_busy` stays zero.
- R4: `cal_busy` equals the accepted vector for exactly `CAL_CYCLES` cycles and is zero afterwards.
- R5: Pending units are served one at a time in ascending index order. During its window, unit i has bit i of `shift_sel` high, and only that bit, for exactly `SHIFT_CYCLES` consecutive cycles.
- R6: The scan starts with a check of unit 0 in the cycle after calibration ends. Each index that is not pending costs 2 cycles (a check and a step). Each pending index costs `SHIFT_CYCLES` + 2 cycles (a check, the window and a retire cycle). The first window cycle follows its check directly.
- R7: Bit i of `shift_busy` stays high through the retire cycle that follows unit i's window and is low from the cycle after it. No bit of `shift_busy` rises while any bit is high.
- R8: `load_strobe` is high for exactly one cycle, in the second cycle after `shift_busy` becomes all zero. The sequencer is idle in the cycle after that.
- R9: Any `cal_req` activity while a run is in progress is ignored. The run's outputs follow the original vector, and nothing restarts when the run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (20 MHz or slower) |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_req | input | N_UNITS | Per-unit calibration request vector |
| cal_busy | output | N_UNITS | Per-unit calibration in progress |
| shift_busy | output | N_UNITS | Per-unit accepted and not yet transferred |
| shift_sel | output | N_UNITS | One-hot select of the unit whose codes are transferring |
| load_strobe | output | 1 | One-cycle parallel-load pulse at the end of a run |

## Verification
A corrupted pending register shows up at once on `shift_busy`, because that output is the register itself. It also shows up later as a window opened for a unit that was never requested, or a requested unit that is skipped. A wrong scan pointer or timer count moves the start of every later window and the strobe by whole cycles, so the error is visible in the first window after the fault. A faulty gate on incoming requests makes `shift_busy` rise two cycles after a stray request, or in the middle of a run.

// File: rtl/term_cal_seq_pkg.sv
// Package: shared state encoding of the calibration request sequencer.
// Assumes: used by term_cal_sequencer only.
package term_cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CAL    = 3'd1,
        ST_CHECK  = 3'd2,
        ST_STEP   = 3'd3,
        ST_XFER   = 3'd4,
        ST_RETIRE = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/tcs_req_gate.sv
// Request gate: accepts a nonzero request vector once it has been seen with
// the same value at two consecutive rising edges while the gate is open.
// Assumes: `open` is high only when the sequencer is idle with nothing
// pending; the history register is cleared whenever the gate is closed.
module tcs_req_gate #(
    parameter int N_UNITS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open,
    input  logic [N_UNITS-1:0] req,
    output logic               accept
);

    logic [N_UNITS-1:0] req_prev;

    // Purpose: remember last edge's request while the gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !open) req_prev <= '0;
        else                 req_prev <= req;
    end

    // Purpose: accept a stable, nonzero request.
    always_comb accept = open && (req != '0) && (req == req_prev);

    // R2: an accepted value must equal the value sampled one edge earlier.
    a_r2_held_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (req == $past(req)));

endmodule

// File: rtl/tcs_step_timer.sv
// Step timer: a shared cycle counter for the calibration phase and the
// transfer windows. Cleared by `start`, counts while `run` is high, and
// flags the cycle whose count equals `limit`.
// Assumes: the two phases never overlap, so one counter serves both.
module tcs_step_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Purpose: count cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // Purpose: final-cycle flag.
    always_comb last = run && (cnt == limit);

    // R4/R5: a running phase never counts past its limit.
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start) |-> (cnt <= limit));

endmodule

// File: rtl/tcs_pend_scan.sv
// Pending scan: holds the set of units still to be transferred and the scan
// pointer, and decodes the pointer to a one-hot unit select.
// Assumes: the pointer may reach N_UNITS (one past the last unit) only
// once the pending set is empty.
module tcs_pend_scan #(
    parameter int N_UNITS = 12,
    parameter int PW      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [N_UNITS-1:0] load_val,
    input  logic               clr_cur,
    input  logic               step,
    input  logic               rewind,
    output logic [N_UNITS-1:0] pend,
    output logic [N_UNITS-1:0] cur_oh,
    output logic               cur_set
);

    logic [PW-1:0] ptr;

    // Purpose: decode the pointer into a one-hot unit select.
    for (genvar i = 0; i < N_UNITS; i++) begin : g_dec
        assign cur_oh[i] = (ptr == PW'(i));
    end

    // Purpose: pending register, loaded on accept, retired bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= '0;
        else if (load)    pend <= load_val;
        else if (clr_cur) pend <= pend & ~cur_oh;
    end

    // Purpose: scan pointer, advanced per index and rewound per run.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr <= '0;
        else if (rewind || load) ptr <= '0;
        else if (step)           ptr <= ptr + 1'b1;
    end

    // Purpose: is the unit under the pointer pending.
    always_comb cur_set = |(pend & cur_oh);

    // R7: retiring is only ever applied to a unit that is pending.
    a_r7_retire_pending: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cur |-> cur_set);

    // R5: pointer never runs past one beyond the last unit.
    a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) <= N_UNITS);

endmodule

// File: rtl/term_cal_sequencer.sv
// Termination calibration request sequencer (top).
// Accepts a stable request vector, holds the selected units in calibration
// for CAL_CYCLES, then serves each pending unit in ascending order with a
// SHIFT_CYCLES transfer window, retires it, and ends with a one-cycle load
// strobe. Requests are only looked at while idle with nothing pending.
// Assumes: clock of 20 MHz or slower (one cycle covers the strobe minimum);
// synchronous active-low reset; calibration time is fixed by parameter.
module term_cal_sequencer
    import term_cal_seq_pkg::*;
#(
    parameter int N_UNITS      = 12,
    parameter int CAL_CYCLES   = 2000,
    parameter int SHIFT_CYCLES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] cal_req,
    output logic [N_UNITS-1:0] cal_busy,
    output logic [N_UNITS-1:0] shift_busy,
    output logic [N_UNITS-1:0] shift_sel,
    output logic               load_strobe
);

    localparam int PW      = $clog2(N_UNITS + 1);
    localparam int MAXLEN  = (CAL_CYCLES > SHIFT_CYCLES) ? CAL_CYCLES : SHIFT_CYCLES;
    localparam int CW      = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] CAL_LIM   = CW'(CAL_CYCLES - 1);
    localparam logic [CW-1:0] SHIFT_LIM = CW'(SHIFT_CYCLES - 1);

    seq_state_t         state, state_nx;
    logic               accept, gate_open;
    logic               tmr_start, tmr_run, tmr_last;
    logic [CW-1:0]      tmr_limit;
    logic [N_UNITS-1:0] pend, cur_oh;
    logic               cur_set, scan_step, scan_clr, scan_rewind;

    // Purpose: gate is open only when idle with nothing pending.
    always_comb gate_open = (state == ST_IDLE) && (pend == '0);

    tcs_req_gate #(.N_UNITS(N_UNITS)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .open   (gate_open),
        .req    (cal_req),
        .accept (accept)
    );

    // Purpose: timer control for calibration and transfer phases.
    always_comb begin
        tmr_start = accept || ((state == ST_CHECK) && (pend != '0) && cur_set);
        tmr_run   = (state == ST_CAL) || (state == ST_XFER);
        tmr_limit = (state == ST_CAL) ? CAL_LIM : SHIFT_LIM;
    end

    tcs_step_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .limit (tmr_limit),
        .last  (tmr_last)
    );

    // Purpose: scan control derived from the current state.
    always_comb begin
        scan_step   = (state == ST_STEP) || (state == ST_RETIRE);
        scan_clr    = (state == ST_RETIRE);
        scan_rewind = (state == ST_DONE);
    end

    tcs_pend_scan #(.N_UNITS(N_UNITS), .PW(PW)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cal_req),
        .clr_cur  (scan_clr),
        .step     (scan_step),
        .rewind   (scan_rewind),
        .pend     (pend),
        .cur_oh   (cur_oh),
        .cur_set  (cur_set)
    );

    // Purpose: next-state decision of the sequencer.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (accept) state_nx = ST_CAL;
            ST_CAL:    if (tmr_last) state_nx = ST_CHECK;
            ST_CHECK:  if (pend == '0)  state_nx = ST_DONE;
                       else if (cur_set) state_nx = ST_XFER;
                       else              state_nx = ST_STEP;
            ST_STEP:   state_nx = ST_CHECK;
            ST_XFER:   if (tmr_last) state_nx = ST_RETIRE;
            ST_RETIRE: state_nx = ST_CHECK;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: drive the port vectors from state and pending set.
    always_comb begin
        cal_busy    = (state == ST_CAL) ? pend : '0;
        shift_busy  = pend;
        shift_sel   = (state == ST_XFER) ? cur_oh : '0;
        load_strobe = (state == ST_DONE);
    end

    // R5: at most one unit is selected for transfer.
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(shift_sel));

    // R5: a selected unit is always one still pending.
    a_r5_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel & ~shift_busy) == '0);

    // R7: no pending bit appears while a run is still pending.
    a_r7_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(shift_busy)) |-> ((shift_busy & ~$past(shift_busy)) == '0));

    // R8: strobe only with nothing pending, and for a single cycle.
    a_r8_strobe_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> (shift_busy == '0));
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);

    // R4: calibration never overlaps a transfer window.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy != '0) |-> (shift_sel == '0));

endmodule

// File: tb/sim_term_cal_sequencer.sv
// Bench: exhaustive sweep of every request vector on a 4-unit build with
// short phases, expected outputs computed arithmetically per cycle.
module sim_term_cal_sequencer;

    localparam int N = 4;
    localparam int C = 5;
    localparam int S = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cal_req = '0;
    logic [N-1:0] cal_busy, shift_busy, shift_sel;
    logic         load_strobe;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    term_cal_sequencer #(.N_UNITS(N), .CAL_CYCLES(C), .SHIFT_CYCLES(S)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_req     (cal_req),
        .cal_busy    (cal_busy),
        .shift_busy  (shift_busy),
        .shift_sel   (shift_sel),
        .load_strobe (load_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected outputs t cycles after the accepting edge, for vector m.
    task automatic expect_at(input int t, input logic [N-1:0] m,
                             output logic [N-1:0] ecal, output logic [N-1:0] ebusy,
                             output logic [N-1:0] esel, output logic estb, output int tend);
        int pos = C;
        logic [N-1:0] left = m;
        logic [N-1:0] gone = '0;
        ecal = (t < C) ? m : '0;
        esel = '0;
        for (int p = 0; p < N; p++) begin
            if (left == '0) break;
            if (m[p]) begin
                if (t >= pos + 1 && t <= pos + S) esel = N'(1) << p;
                if (t >= pos + S + 2) gone[p] = 1'b1;
                left[p] = 1'b0;
                pos += S + 2;
            end else begin
                pos += 2;
            end
        end
        ebusy = m & ~gone;
        estb  = (t == pos + 1);
        tend  = pos + 2;
    endtask

    task automatic all_zero(input string tag);
        chk(cal_busy == '0,   {tag, " cal_busy"},   32'(cal_busy), 0);
        chk(shift_busy == '0, {tag, " shift_busy"}, 32'(shift_busy), 0);
        chk(shift_sel == '0,  {tag, " shift_sel"},  32'(shift_sel), 0);
        chk(load_strobe == 1'b0, {tag, " load_strobe"}, 32'(load_strobe), 0);
    endtask

    // One full run for vector m, with stray requests injected mid-run (R9).
    task automatic run_vec(input logic [N-1:0] m);
        logic [N-1:0] ecal, ebusy, esel;
        logic estb;
        int tend;
        cal_req = m;
        @(negedge clk);
        @(negedge clk);
        cal_req = '0;
        expect_at(0, m, ecal, ebusy, esel, estb, tend);
        for (int t = 0; t <= tend + 2; t++) begin
            expect_at(t, m, ecal, ebusy, esel, estb, tend);
            if (t == 0) chk(shift_busy == m, "R2 accepted vector", 32'(shift_busy), 32'(m));
            chk(cal_busy == ecal,       "R4 cal_busy",            32'(cal_busy), 32'(ecal));
            chk(shift_sel == esel,      "R5/R6 shift_sel",        32'(shift_sel), 32'(esel));
            chk(shift_busy == ebusy,    "R7 shift_busy",          32'(shift_busy), 32'(ebusy));
            chk(load_strobe == estb,    "R8 load_strobe",         32'(load_strobe), 32'(estb));
            if (t == 2)     cal_req = '1;   // R9 stray during calibration
            if (t == 5)     cal_req = '0;
            if (t == C + 3) cal_req = ~m;   // R9 stray during scan
            if (t == C + 7) cal_req = '0;
            @(negedge clk);
        end
        all_zero("R9 no restart");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        all_zero("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R1 after release");

        // R3: one-edge pulse is ignored.
        cal_req = 4'b0101;
        @(negedge clk);
        cal_req = '0;
        for (int k = 0; k < 4; k++) begin
            chk(shift_busy == '0, "R3 single edge", 32'(shift_busy), 0);
            @(negedge clk);
        end
        // R3: value changing between edges is ignored.
        cal_req = 4'b0001;
        @(negedge clk);
        cal_req = 4'b0010;
        @(negedge clk);
        cal_req = '0;
        for (int k = 0; k < 4; k++) begin
            chk(shift_busy == '0, "R3 changing value", 32'(shift_busy), 0);
            @(negedge clk);
        end

        // Exhaustive sweep of all nonzero vectors (R2, R4..R9).
        for (int v = 1; v < (1 << N); v++) begin
            run_vec(N'(v));
        end

        // R1: reset in the middle of a run abandons it.
        cal_req = '1;
        @(negedge clk);
        @(negedge clk);
        cal_req = '0;
        for (int k = 0; k < C + 3; k++) @(negedge clk);
        chk(shift_busy == '1, "R1 pre-reset busy", 32'(shift_busy), 32'((1 << N) - 1));
        rst_n = 1'b0;
        @(negedge clk);
        all_zero("R1 mid-run reset");
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            all_zero("R1 stays idle");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 100000; k++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule